// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, looking only at its 6-byte destination address. The address arrives one byte per clock, first byte first. A start strobe marks the cycle that carries the first byte. While the bytes stream in, the block updates three things. It tracks whether each byte equals the matching byte of the programmed station address. It tracks whether every byte is all ones. It runs a byte-serial CRC-32 over the address.

One cycle after the last address byte, a single-cycle done strobe rises, together with the accept/reject verdict. The verdict follows a fixed priority:

1. Promiscuous mode accepts everything.
2. A broadcast address is accepted unless broadcast reception is disabled.
3. With pass-all-multicast set, every multicast address is accepted.
4. Otherwise unicast and multicast each use either exact station-address matching (optionally inverted) or a 64-bit hash table indexed by the top six CRC bits.

The mode flags are captured at the start strobe, so software can change them at any time without corrupting a frame that is already in flight. The station address and the hash table are treated as static configuration.

Top module: `eth_dst_filter`

## Requirements
- R1: When the promiscuous flag captured at start is 1, the verdict is accept for any address.
- R2: With promiscuous clear, an address whose six bytes are all 0xFF is accepted if the broadcast-disable flag is 0 and rejected if it is 1, whatever the other flags and tables hold.
- R3: An address is multicast when bit 0 of its first received byte is 1. With promiscuous clear, a non-broadcast multicast address is accepted when pass-all-multicast is 1.
- R4: A unicast address with the unicast-hash flag clear is accepted exactly when all six bytes equal the station address. Station byte k sits in bits 8k+7:8k of the station input, and byte 0 is compared with the first received byte.
- R5: The invert flag inverts the exact-match result only. It has no effect on the broadcast, pass-all, promiscuous or hash verdicts.
- R6: A multicast address with pass-all-multicast clear and the multicast-hash flag clear uses the exact-match rule of R4/R5.
- R7: When the flag for the address kind (multicast-hash or unicast-hash) is set, the verdict is one hash-table bit. Its index is bits 31:26 of the CRC. The CRC is computed LSB-first with polynomial 0xEDB88320, seeded with all ones, over the six bytes in arrival order, with no final inversion. Index bit 5 = 1 selects the high table word, and index bits 4:0 pick the bit within the selected word.
- R8: done_o is high for exactly one cycle, the cycle after the sixth address byte is taken. Bytes may be separated by idle cycles. accept_o is 0 whenever done_o is 0.
- R9: A start strobe during an unfinished address abandons it. Only the new address produces a done_o, and its verdict depends only on the new bytes.
- R10: The six mode flags are captured in the start cycle. Changing them afterwards does not change the verdict of that address.
- R11: Valid bytes outside an address (before any start, or after the sixth byte) are ignored and raise no done_o.
- R12: During and right after reset, done_o and accept_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Marks the cycle carrying the first address byte (byte_vld_i not needed in that cycle) |
| byte_vld_i | input | 1 | A later address byte is present on byte_i |
| byte_i | input | 8 | Address byte |
| station_addr_i | input | 48 | Station address, byte k in bits 8k+7:8k |
| hash_hi_i | input | 32 | Hash table word for index bit 5 = 1 |
| hash_lo_i | input | 32 | Hash table word for index bit 5 = 0 |
| promisc_i | input | 1 | Accept all addresses |
| bcast_dis_i | input | 1 | Reject broadcast |
| mcast_all_i | input | 1 | Accept all multicast |
| mcast_hash_i | input | 1 | Multicast uses the hash table |
| ucast_hash_i | input | 1 | Unicast uses the hash table |
| invert_i | input | 1 | Invert the exact-match result |
| done_o | output | 1 | Verdict strobe |
| accept_o | output | 1 | Verdict, valid with done_o |

## Verification
The bench computes the hash index bit by bit over the 48 address bits, a different route from the RTL's byte loop. For each address it builds a table holding only the indexed bit, then the complement of that table. A design that reversed the CRC bit order, inverted the final value or swapped the table words would flip one of these two verdicts.

The bench also checks the priority between the rules. A broadcast address is multicast too, so a design that tested multicast before broadcast would let pass-all-multicast override broadcast-disable. A design that applied invert outside exact matching would corrupt the hash verdicts.

Timing is probed with idle gaps between bytes, with restarts after a partial address, with stray bytes, and with flags changed in mid-address. These catch a done that is one cycle early or late, a counter that is not cleared on restart, and flags read live instead of captured at start.

// File: rtl/eth_dst_filter_pkg.sv
package eth_dst_filter_pkg;

  localparam int CRC_W = 32;

  typedef struct packed {
    logic promisc;
    logic bcast_dis;
    logic mcast_all;
    logic mcast_hash;
    logic ucast_hash;
    logic invert;
  } filt_ctrl_t;

  // One byte of an LSB-first CRC update.
  function automatic logic [CRC_W-1:0] crc_step_byte(
    input logic [CRC_W-1:0] crc_in,
    input logic [7:0]       data,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] c;
    c = crc_in ^ {{(CRC_W-8){1'b0}}, data};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/dst_byte_seq.sv
module dst_byte_seq #(
  parameter int N_BYTES = 6,
  localparam int CNT_W = $clog2(N_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_vld_i,
  output logic             take_o,
  output logic             first_o,
  output logic             last_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             active;

  // An address is open after start until N_BYTES bytes have been taken.
  assign active     = (cnt_q != '0) && (cnt_q < CNT_W'(N_BYTES));
  assign first_o    = start_i;
  assign take_o     = start_i | (byte_vld_i & active);
  assign byte_idx_o = start_i ? '0 : cnt_q;
  assign last_o     = take_o && (byte_idx_o == CNT_W'(N_BYTES - 1));
  assign done_o     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (start_i) begin
        cnt_q <= CNT_W'(1);
      end else if (take_o) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/dst_crc_acc.sv
module dst_crc_acc
  import eth_dst_filter_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY  = 32'hEDB8_8320,
  parameter int               OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             first_i,
  input  logic [7:0]       byte_i,
  output logic [OUT_W-1:0] top_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_next;

  // A start reseeds the register, so no state leaks from an older address.
  assign crc_base = first_i ? '1 : crc_q;
  assign crc_next = crc_step_byte(crc_base, byte_i, POLY);
  assign top_o    = crc_q[CRC_W-1 -: OUT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (take_i) begin
      crc_q <= crc_next;
    end
  end

endmodule

// File: rtl/dst_addr_track.sv
module dst_addr_track #(
  parameter int N_BYTES = 6,
  localparam int CNT_W = $clog2(N_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic               first_i,
  input  logic [CNT_W-1:0]   byte_idx_i,
  input  logic [7:0]         byte_i,
  input  logic [8*N_BYTES-1:0] station_i,
  output logic               match_o,
  output logic               bcast_o,
  output logic               mcast_o
);

  logic       match_q, bcast_q, mcast_q;
  logic [7:0] ref_byte;
  logic       match_base, bcast_base;

  // Select the station byte that lines up with the incoming byte.
  always_comb begin
    ref_byte = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      if (byte_idx_i == CNT_W'(i)) ref_byte = station_i[8*i +: 8];
    end
  end

  assign match_base = first_i ? 1'b1 : match_q;
  assign bcast_base = first_i ? 1'b1 : bcast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
    end else if (take_i) begin
      match_q <= match_base & (byte_i == ref_byte);
      bcast_q <= bcast_base & (byte_i == 8'hFF);
      if (first_i) mcast_q <= byte_i[0];
    end
  end

  assign match_o = match_q;
  assign bcast_o = bcast_q;
  assign mcast_o = mcast_q;

endmodule

// File: rtl/dst_decide.sv
module dst_decide
  import eth_dst_filter_pkg::*;
#(
  parameter int TBL_W = 32,
  localparam int SEL_W = $clog2(TBL_W),
  localparam int IDX_W = SEL_W + 1
) (
  input  filt_ctrl_t       ctrl_i,
  input  logic             match_i,
  input  logic             bcast_i,
  input  logic             mcast_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TBL_W-1:0] hash_hi_i,
  input  logic [TBL_W-1:0] hash_lo_i,
  output logic             use_hash_o,
  output logic             hash_hit_o,
  output logic             accept_o
);

  function automatic logic table_bit(
    input logic [IDX_W-1:0] idx,
    input logic [TBL_W-1:0] hi,
    input logic [TBL_W-1:0] lo
  );
    return idx[SEL_W] ? hi[idx[SEL_W-1:0]] : lo[idx[SEL_W-1:0]];
  endfunction

  assign use_hash_o = mcast_i ? ctrl_i.mcast_hash : ctrl_i.ucast_hash;
  assign hash_hit_o = table_bit(idx_i, hash_hi_i, hash_lo_i);

  // Priority: promiscuous, broadcast, pass-all multicast, hash, exact.
  always_comb begin
    if (ctrl_i.promisc)                  accept_o = 1'b1;
    else if (bcast_i)                    accept_o = ~ctrl_i.bcast_dis;
    else if (mcast_i && ctrl_i.mcast_all) accept_o = 1'b1;
    else if (use_hash_o)                 accept_o = hash_hit_o;
    else                                 accept_o = match_i ^ ctrl_i.invert;
  end

endmodule

// File: rtl/eth_dst_filter.sv
module eth_dst_filter
  import eth_dst_filter_pkg::*;
#(
  parameter int               N_BYTES = 6,
  parameter int               TBL_W   = 32,
  parameter logic [CRC_W-1:0] POLY    = 32'hEDB8_8320,
  localparam int CNT_W = $clog2(N_BYTES + 1),
  localparam int IDX_W = $clog2(TBL_W) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 byte_vld_i,
  input  logic [7:0]           byte_i,
  input  logic [8*N_BYTES-1:0] station_addr_i,
  input  logic [TBL_W-1:0]     hash_hi_i,
  input  logic [TBL_W-1:0]     hash_lo_i,
  input  logic                 promisc_i,
  input  logic                 bcast_dis_i,
  input  logic                 mcast_all_i,
  input  logic                 mcast_hash_i,
  input  logic                 ucast_hash_i,
  input  logic                 invert_i,
  output logic                 done_o,
  output logic                 accept_o
);

  filt_ctrl_t       ctrl_in, ctrl_q;
  logic             take_ev, first_ev, last_ev;
  logic [CNT_W-1:0] byte_idx;
  logic [IDX_W-1:0] hash_idx;
  logic             is_match, is_bcast, is_mcast;
  logic             use_hash, hash_hit, verdict;

  assign ctrl_in = '{promisc: promisc_i, bcast_dis: bcast_dis_i,
                     mcast_all: mcast_all_i, mcast_hash: mcast_hash_i,
                     ucast_hash: ucast_hash_i, invert: invert_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (start_i) ctrl_q <= ctrl_in;
  end

  dst_byte_seq #(.N_BYTES(N_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .take_o(take_ev), .first_o(first_ev), .last_o(last_ev),
    .byte_idx_o(byte_idx), .done_o(done_o)
  );

  dst_crc_acc #(.POLY(POLY), .OUT_W(IDX_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .take_i(take_ev), .first_i(first_ev),
    .byte_i(byte_i), .top_o(hash_idx)
  );

  dst_addr_track #(.N_BYTES(N_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .take_i(take_ev), .first_i(first_ev),
    .byte_idx_i(byte_idx), .byte_i(byte_i), .station_i(station_addr_i),
    .match_o(is_match), .bcast_o(is_bcast), .mcast_o(is_mcast)
  );

  dst_decide #(.TBL_W(TBL_W)) u_decide (
    .ctrl_i(ctrl_q), .match_i(is_match), .bcast_i(is_bcast),
    .mcast_i(is_mcast), .idx_i(hash_idx), .hash_hi_i(hash_hi_i),
    .hash_lo_i(hash_lo_i), .use_hash_o(use_hash), .hash_hit_o(hash_hit),
    .accept_o(verdict)
  );

  assign accept_o = done_o & verdict;

endmodule

// File: rtl/eth_dst_filter_chk.sv
module eth_dst_filter_chk
  import eth_dst_filter_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       done_o,
  input logic       accept_o,
  input logic       last_ev,
  input filt_ctrl_t ctrl_q,
  input logic       is_bcast,
  input logic       is_mcast,
  input logic       use_hash,
  input logic       hash_hit
);

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> done_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_accept_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !accept_o);

  p_promisc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ctrl_q.promisc) |-> accept_o);

  p_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ctrl_q.promisc && is_bcast) |-> (accept_o == !ctrl_q.bcast_dis));

  p_mcast_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ctrl_q.promisc && !is_bcast && is_mcast && ctrl_q.mcast_all)
      |-> accept_o);

  p_hash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ctrl_q.promisc && !is_bcast && !(is_mcast && ctrl_q.mcast_all)
      && use_hash) |-> (accept_o == hash_hit));

  p_ctrl_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(ctrl_q));

endmodule

bind eth_dst_filter eth_dst_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .accept_o(accept_o), .last_ev(last_ev), .ctrl_q(ctrl_q),
  .is_bcast(is_bcast), .is_mcast(is_mcast), .use_hash(use_hash),
  .hash_hit(hash_hit)
);

// File: tb/eth_dst_filter_tb_top.sv
module eth_dst_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [47:0] station = 48'h5A_4B_3C_2D_1E_02;
  logic [31:0] hash_hi = '0, hash_lo = '0;
  // fl = {promisc, bcast_dis, mcast_all, mcast_hash, ucast_hash, invert}
  logic [5:0]  fl = '0;
  logic        done_o, accept_o;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  eth_dst_filter dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .station_addr_i(station), .hash_hi_i(hash_hi),
    .hash_lo_i(hash_lo), .promisc_i(fl[5]), .bcast_dis_i(fl[4]),
    .mcast_all_i(fl[3]), .mcast_hash_i(fl[2]), .ucast_hash_i(fl[1]),
    .invert_i(fl[0]), .done_o(done_o), .accept_o(accept_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bit-serial index: 48 single-bit steps over the address, LSB of byte 0 first.
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int j = 0; j < 48; j++) begin
      logic fb = c[0] ^ a[j];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a, input logic [5:0] f);
    logic [5:0] ix;
    if (f[5]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !f[4];
    if (a[0] && f[3]) return 1'b1;
    if (a[0] ? f[2] : f[1]) begin
      ix = ref_index(a);
      return ix[5] ? hash_hi[ix[4:0]] : hash_lo[ix[4:0]];
    end
    return (a == station) ^ f[0];
  endfunction

  // Sends one address; gap inserts an idle cycle before byte `gap`;
  // when mid_en, flags change to mid_fl after the first byte.
  task automatic run_frame(input logic [47:0] a, input string req, input int gap,
                           input bit mid_en, input logic [5:0] mid_fl);
    logic exp = ref_accept(a, fl);
    @(negedge clk); start_i = 1; byte_vld_i = 1; byte_i = a[7:0];
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      start_i = 0;
      if (mid_en) fl = mid_fl;
      chk({req, " R8 early done"}, 32'(done_o), 0);
      if (i == gap) begin
        byte_vld_i = 0; byte_i = 8'hFF;
        @(negedge clk);
        chk({req, " R8 done in gap"}, 32'(done_o), 0);
      end
      byte_vld_i = 1; byte_i = a[8*i +: 8];
    end
    @(negedge clk); byte_vld_i = 0;
    chk({req, " R8 done"}, 32'(done_o), 1);
    chk({req, " verdict"}, 32'(accept_o), 32'(exp));
    @(negedge clk);
    chk({req, " R8 single"}, 32'(done_o), 0);
    chk({req, " R8 accept low"}, 32'(accept_o), 0);
  endtask

  task automatic t_reset();
    chk("R12 done in reset", 32'(done_o), 0);
    chk("R12 accept in reset", 32'(accept_o), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R12 done after reset", 32'(done_o), 0);
  endtask

  task automatic t_promisc();
    fl = 6'b100000; run_frame(48'h11_22_33_44_55_66, "R1 promisc unicast", 0, 0, 0);
    fl = 6'b110001; run_frame(48'hFFFF_FFFF_FFFF, "R1 promisc bcast", 0, 0, 0);
  endtask

  task automatic t_bcast();
    fl = 6'b000000; run_frame(48'hFFFF_FFFF_FFFF, "R2 bcast accept", 0, 0, 0);
    fl = 6'b010000; run_frame(48'hFFFF_FFFF_FFFF, "R2 bcast disabled", 0, 0, 0);
    fl = 6'b011101; run_frame(48'hFFFF_FFFF_FFFF, "R2 bcast beats pass-all", 0, 0, 0);
  endtask

  task automatic t_mcast_all();
    fl = 6'b001000; run_frame(48'h99_88_77_66_55_01, "R3 pass-all multicast", 0, 0, 0);
    fl = 6'b001000; run_frame(48'h99_88_77_66_55_02, "R3 unicast not passed", 0, 0, 0);
  endtask

  task automatic t_perfect();
    fl = 6'b000000; run_frame(station, "R4 exact match", 2, 0, 0);
    run_frame(station ^ 48'h01_00_00_00_00_00, "R4 last byte differs", 0, 0, 0);
    run_frame(station ^ 48'h00_00_00_00_00_80, "R4 first byte differs", 4, 0, 0);
    fl = 6'b000001; run_frame(station, "R5 invert exact", 0, 0, 0);
    run_frame(48'h10_20_30_40_50_60, "R5 invert mismatch", 0, 0, 0);
    station = 48'h01_02_03_04_05_07;
    fl = 6'b000000; run_frame(station, "R6 multicast exact", 0, 0, 0);
    run_frame(48'h01_02_03_04_05_09, "R6 multicast mismatch", 0, 0, 0);
    station = 48'h5A_4B_3C_2D_1E_02;
  endtask

  task automatic t_hash();
    logic [47:0] a;
    logic [5:0]  ix;
    for (int k = 0; k < 10; k++) begin
      a = {8'(k * 37), 8'(k * 11 + 3), 8'hC4, 8'(k), 8'h5E, 7'(k * 5), k[0]};
      ix = ref_index(a);
      hash_hi = ix[5] ? (32'h1 << ix[4:0]) : 32'h0;
      hash_lo = ix[5] ? 32'h0 : (32'h1 << ix[4:0]);
      fl = a[0] ? 6'b000101 : 6'b000011;  // invert set: must not matter
      run_frame(a, "R7 hash bit set", 0, 0, 0);
      chk("R7 hash hit", 32'(ref_accept(a, fl)), 1);
      hash_hi = ~hash_hi; hash_lo = ~hash_lo;
      run_frame(a, "R7 hash bit clear", 3, 0, 0);
    end
    hash_hi = '0; hash_lo = '0;
  endtask

  task automatic t_restart();
    fl = 6'b000000;
    @(negedge clk); start_i = 1; byte_vld_i = 1; byte_i = station[7:0];
    for (int i = 1; i < 4; i++) begin
      @(negedge clk); start_i = 0; byte_i = station[8*i +: 8];
    end
    run_frame(48'h0A_0B_0C_0D_0E_10, "R9 restart mismatch", 0, 0, 0);
    @(negedge clk); start_i = 1; byte_vld_i = 1; byte_i = 8'h44;
    @(negedge clk); start_i = 0; byte_i = 8'h45;
    run_frame(station, "R9 restart match", 0, 0, 0);
  endtask

  task automatic t_ctrl_sample();
    fl = 6'b100000;
    run_frame(48'h77_66_55_44_33_22, "R10 promisc dropped mid", 0, 1, 6'b000000);
    fl = 6'b010000;
    run_frame(48'hFFFF_FFFF_FFFF, "R10 bcast_dis dropped mid", 0, 1, 6'b000000);
    fl = 6'b000000;
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); byte_vld_i = 1; byte_i = station[7:0];
      @(negedge clk);
      chk("R11 stray byte after frame", 32'(done_o), 0);
      chk("R11 stray accept", 32'(accept_o), 0);
    end
    byte_vld_i = 0;
  endtask

  initial begin
    t_reset();
    t_ignore();
    t_promisc();
    t_bcast();
    t_mcast_all();
    t_perfect();
    t_hash();
    t_restart();
    t_ignore();
    t_ctrl_sample();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule